// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Selector

This block picks, once per switching cycle, how a synchronous buck power stage is driven. It chooses between fixed-frequency PWM operation and a light-load hysteretic mode in which the low-side switch stays off (diode emulation). It watches a phase-polarity bit that is sampled when each low-side conduction interval ends. A positive bit means the inductor current has reversed; a negative bit means it is still flowing forward. A run of identical samples moves the converter between modes. A forced-PWM input and an undervoltage escape override that filter.

The analog comparators and the PWM modulator are modelled as digital inputs. The `pwm_req` input is the modulator's high-side demand. In hysteretic mode, the lower and upper limit flags of the output comparator start and stop each high-side current pulse. The block's output is a mode flag together with the high-side and low-side gate commands. A four-state machine handles the mode changes. Its states are `ST_PWM` and `ST_HYST`, plus two one-clock break states, `ST_TO_HYST` and `ST_TO_PWM`, in which both switches are off. The named transitions are:

- enter-light: `ST_PWM` goes to `ST_TO_HYST`.
- settle-light: `ST_TO_HYST` goes to `ST_HYST`.
- leave-light: `ST_HYST` goes to `ST_TO_PWM`, on the negative-run, load-step or force condition.
- abort: `ST_TO_HYST` goes to `ST_TO_PWM` when forced.
- settle-pwm: `ST_TO_PWM` goes to `ST_PWM`.
- disable: any state goes to `ST_PWM` when `run_en` is low.

Top module: `buck_mode_sel`

## Requirements
- R1: The polarity bit is counted only in a clock where `cyc_tick` is 1. With `cyc_tick` at 0, `phase_pos` has no effect on the mode, however long it is held.
- R2: In PWM mode, 8 consecutive ticks with `phase_pos`=1 (1 = positive phase, reverse current) trigger enter-light. After 7 such ticks the block is still in PWM mode.
- R3: In hysteretic mode, 8 consecutive ticks with `phase_pos`=0 trigger leave-light. A tick of the opposite polarity restarts the run from zero, in either mode.
- R4: In hysteretic mode the low-side command is always 0. `hs_on` rises on the clock edge that sees `hyst_lo`=1. It stays high until the edge that sees `hyst_hi`=1; if both flags are 1 on the same edge, `hyst_hi` wins. Between pulses both commands are 0.
- R5: A mode change passes through exactly one break clock. During that clock `hs_on`=0, `ls_on`=0 and `mode_hyst`=0. The next state, and so the next value of `mode_hyst`, takes effect one clock edge after the triggering tick.
- R6: In hysteretic mode, a tick that arrives while `hyst_lo` is still 1 causes leave-light on that edge, whatever the polarity.
- R7: While `force_pwm`=1, the run count is held at zero and the block never enters or stays in hysteretic mode. From `ST_HYST` or `ST_TO_HYST` it leaves through `ST_TO_PWM`. Positive ticks seen before `force_pwm` was asserted do not count toward the run afterwards.
- R8: An asynchronous reset (`rst_n`=0) puts the block in `ST_PWM` with the run count at zero, and so does `run_en`=0 on any clock edge. Ticks seen before the disable do not count afterwards.
- R9: In `ST_PWM`, `hs_on` equals `pwm_req` and `ls_on` equals its inverse. The two gate commands are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | 1 = controller enabled and supply above lockout; 0 forces PWM state |
| cyc_tick | input | 1 | One-clock strobe at the end of each low-side conduction interval |
| phase_pos | input | 1 | Sampled phase polarity, 1 = positive (reverse current) |
| hyst_lo | input | 1 | Output at or below the hysteretic lower limit |
| hyst_hi | input | 1 | Output at or above the hysteretic upper limit |
| force_pwm | input | 1 | 1 = hysteretic operation disabled |
| pwm_req | input | 1 | High-side demand from the PWM modulator |
| mode_hyst | output | 1 | 1 while in the settled hysteretic state |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |

## Verification
A run counter that is off by one shows up at the ports as a missing or early break clock. The outputs then read all-off with `mode_hyst` low one edge after the seventh tick instead of the eighth, or after the ninth. A count that is not cleared by an opposite-polarity tick, a force or a disable shows in the same way: the block changes mode a few ticks early in the scenario that follows. A wrong state shows within one clock, as `mode_hyst` or a gate command that disagrees with the expected break or settled value on the next edge.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic [1:0] {
        ST_PWM     = 2'd0,
        ST_TO_HYST = 2'd1,
        ST_HYST    = 2'd2,
        ST_TO_PWM  = 2'd3
    } mode_state_t;

endpackage

// File: rtl/polarity_run_filter.sv
module polarity_run_filter #(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic sample,
    output logic hit
);
    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (!sample)
                cnt_q <= '0;
            else if (cnt_q != FULL)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = tick && sample && !clr && (cnt_q == LAST);

    // R2: the run count never passes its saturation value
    p_cnt_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R7: a clear request leaves the count at zero on the next edge
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R3: an opposite-polarity tick restarts the run
    p_opposite_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sample) |=> (cnt_q == '0));
endmodule

// File: rtl/hyst_pulse_gen.sv
module hyst_pulse_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lo_lim,
    input  logic hi_lim,
    output logic pulse
);
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else if (!active || hi_lim)
            pulse_q <= 1'b0;
        else if (lo_lim)
            pulse_q <= 1'b1;
    end

    assign pulse = pulse_q;

    // R4: the upper limit always ends a pulse
    p_hi_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hi_lim |=> !pulse_q);
endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import buck_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic        tick,
    input  logic        lo_lim,
    input  logic        force_pwm,
    input  logic        run_hit,
    input  logic        pulse,
    input  logic        pwm_req,
    output mode_state_t state,
    output logic        mode_hyst,
    output logic        hs_on,
    output logic        ls_on
);
    mode_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!run_en) begin
            state_d = ST_PWM;
        end else begin
            unique case (state_q)
                ST_PWM:     if (run_hit) state_d = ST_TO_HYST;
                ST_TO_HYST: state_d = force_pwm ? ST_TO_PWM : ST_HYST;
                ST_HYST:    if (force_pwm || (tick && lo_lim) || run_hit)
                                state_d = ST_TO_PWM;
                ST_TO_PWM:  state_d = ST_PWM;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_PWM;
        else
            state_q <= state_d;
    end

    always_comb begin
        mode_hyst = 1'b0;
        hs_on     = 1'b0;
        ls_on     = 1'b0;
        unique case (state_q)
            ST_PWM: begin
                hs_on = pwm_req;
                ls_on = !pwm_req;
            end
            ST_HYST: begin
                mode_hyst = 1'b1;
                hs_on     = pulse;
            end
            ST_TO_HYST, ST_TO_PWM: ;
        endcase
    end

    assign state = state_q;

    // R5: both switches are off in a break state
    p_break_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TO_HYST || state_q == ST_TO_PWM) |-> (!hs_on && !ls_on));

    // R6: a tick with the lower limit still set escapes hysteretic mode
    p_escape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && state_q == ST_HYST && tick && lo_lim) |=> (state_q == ST_TO_PWM));

    // R7: the force input keeps the block out of hysteretic mode
    p_force_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_pwm |=> !mode_hyst);

    // R8: disable returns to PWM state
    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_PWM));

    // R4: the low side stays off in hysteretic mode
    p_hyst_ls_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HYST) |-> !ls_on);
endmodule

// File: rtl/buck_mode_sel.sv
module buck_mode_sel
    import buck_mode_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic cyc_tick,
    input  logic phase_pos,
    input  logic hyst_lo,
    input  logic hyst_hi,
    input  logic force_pwm,
    input  logic pwm_req,
    output logic mode_hyst,
    output logic hs_on,
    output logic ls_on
);
    mode_state_t state;
    logic        in_hyst;
    logic        in_break;
    logic        filt_clr;
    logic        filt_sample;
    logic        run_hit;
    logic        pulse;

    assign in_hyst     = (state == ST_HYST);
    assign in_break    = (state == ST_TO_HYST) || (state == ST_TO_PWM);
    assign filt_clr    = !run_en || force_pwm || in_break;
    assign filt_sample = in_hyst ? !phase_pos : phase_pos;

    polarity_run_filter #(.RUN_LEN(RUN_LEN)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (filt_clr),
        .tick   (cyc_tick),
        .sample (filt_sample),
        .hit    (run_hit)
    );

    hyst_pulse_gen u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (in_hyst),
        .lo_lim (hyst_lo),
        .hi_lim (hyst_hi),
        .pulse  (pulse)
    );

    mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .tick      (cyc_tick),
        .lo_lim    (hyst_lo),
        .force_pwm (force_pwm),
        .run_hit   (run_hit),
        .pulse     (pulse),
        .pwm_req   (pwm_req),
        .state     (state),
        .mode_hyst (mode_hyst),
        .hs_on     (hs_on),
        .ls_on     (ls_on)
    );

    // R9: no shoot-through
    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on && ls_on));
endmodule

// File: tb/buck_mode_sel_bench.sv
module buck_mode_sel_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b1, cyc_tick = 1'b0, phase_pos = 1'b0;
    logic hyst_lo = 1'b0, hyst_hi = 1'b0, force_pwm = 1'b0, pwm_req = 1'b0;
    logic mode_hyst, hs_on, ls_on;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic  m;
        logic  h;
        logic  l;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    buck_mode_sel u_buck_mode_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .cyc_tick  (cyc_tick),
        .phase_pos (phase_pos),
        .hyst_lo   (hyst_lo),
        .hyst_hi   (hyst_hi),
        .force_pwm (force_pwm),
        .pwm_req   (pwm_req),
        .mode_hyst (mode_hyst),
        .hs_on     (hs_on),
        .ls_on     (ls_on)
    );

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #3;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (mode_hyst !== e.m || hs_on !== e.h || ls_on !== e.l) begin
                n_fail++;
                $display("FAIL %s: got mode=%b hs=%b ls=%b expected mode=%b hs=%b ls=%b",
                         e.tag, mode_hyst, hs_on, ls_on, e.m, e.h, e.l);
            end
        end
    end

    // driver: inputs set at the falling edge, expectation for the next rising edge
    task automatic step(input logic tk, input logic pp, input logic lo, input logic hi,
                        input logic fp, input logic rq, input logic ru,
                        input bit chk, input logic em, input logic eh, input logic el,
                        input string tag);
        @(negedge clk);
        cyc_tick = tk; phase_pos = pp; hyst_lo = lo; hyst_hi = hi;
        force_pwm = fp; pwm_req = rq; run_en = ru;
        if (chk) begin
            exp_t e;
            e.m = em; e.h = eh; e.l = el; e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk);
    endtask

    // n ticks of one polarity, checking only after the last one
    task automatic ticks(input int n, input logic pp, input logic fp,
                         input bit chk, input logic em, input logic eh, input logic el,
                         input string tag);
        for (int i = 0; i < n; i++)
            step(1, pp, 0, 0, fp, 1, 1, chk && (i == n - 1), em, eh, el, tag);
    endtask

    task automatic idle(input bit chk, input logic em, input logic eh, input logic el,
                        input string tag);
        step(0, 0, 0, 0, 0, 1, 1, chk, em, eh, el, tag);
    endtask

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state, R9 mapping with low demand
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1, "R8 reset state");
        step(0, 0, 0, 0, 0, 1, 1, 1, 0, 1, 0, "R9 pwm high demand");
        // R1 polarity without tick is ignored
        for (int i = 0; i < 20; i++)
            step(0, 1, 0, 0, 0, 1, 1, i == 19, 0, 1, 0, "R1 no tick no count");
        // R2 run of positive ticks
        ticks(7, 1, 0, 1, 0, 1, 0, "R2 seven ticks stay pwm");
        ticks(1, 1, 0, 1, 0, 0, 0, "R5 break to hyst");
        idle(1, 1, 0, 0, "R2 settled hyst, R4 both off");
        // R4 pulse
        step(0, 0, 1, 0, 0, 1, 1, 1, 1, 1, 0, "R4 pulse start");
        step(0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 0, "R4 pulse held");
        step(0, 0, 0, 1, 0, 1, 1, 1, 1, 0, 0, "R4 pulse end");
        step(0, 0, 1, 1, 0, 1, 1, 1, 1, 0, 0, "R4 upper wins");
        // R3 negative run with restart
        ticks(7, 0, 0, 1, 1, 0, 0, "R3 seven neg stay hyst");
        ticks(1, 1, 0, 1, 1, 0, 0, "R3 positive tick");
        ticks(7, 0, 0, 1, 1, 0, 0, "R3 run restarted");
        ticks(1, 0, 0, 1, 0, 0, 0, "R5 break to pwm");
        idle(1, 0, 1, 0, "R3 back in pwm");
        // R6 load-step escape
        ticks(8, 1, 0, 1, 0, 0, 0, "R5 break to hyst");
        idle(1, 1, 0, 0, "R6 setup hyst");
        step(1, 1, 1, 0, 0, 1, 1, 1, 0, 0, 0, "R6 escape");
        idle(1, 0, 1, 0, "R6 pwm");
        // R7 force clears partial run
        ticks(5, 1, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 0, "R7 forced pwm");
        idle(0, 0, 0, 0, "");
        ticks(7, 1, 0, 1, 0, 1, 0, "R7 count held zero");
        ticks(1, 1, 0, 1, 0, 0, 0, "R5 break to hyst");
        idle(1, 1, 0, 0, "R7 setup hyst");
        step(0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, "R7 hyst exit");
        step(0, 0, 0, 0, 1, 1, 1, 1, 0, 1, 0, "R7 pwm");
        ticks(10, 1, 1, 1, 0, 1, 0, "R7 blocked");
        idle(0, 0, 0, 0, "");
        // R8 disable
        ticks(8, 1, 0, 0, 0, 0, 0, "");
        idle(1, 1, 0, 0, "R8 setup hyst");
        step(0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0, "R8 disable to pwm");
        idle(0, 0, 0, 0, "");
        ticks(5, 1, 0, 0, 0, 0, 0, "");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
        idle(0, 0, 0, 0, "");
        ticks(7, 1, 0, 1, 0, 1, 0, "R8 count cleared");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 1, "R9 pwm low demand");
        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule